// File: doc/BRIEF.md
# Self-Synchronizing Serial Randomizer

This block whitens a bit-serial telemetry stream so that long runs of identical bits do not reach the transmitter. Each accepted bit is combined by XOR with two late taps of a 15-stage shift register. In randomize mode the combined output bit is shifted back into the register. Because the register is loaded only from the line stream, a receiver built from the same block in de-randomize mode locks onto the sender by itself, with no shared seed or frame alignment.

A mode input selects the direction. In de-randomize mode the received bit, and not the output, enters the register. A bypass input forwards data unchanged and freezes the register. A synchronous clear returns the register to all zeros before a stream starts. Input bits carry a valid strobe. The block registers its output once, so valid and data leave together one cycle after they arrive.

Top module: `self_sync_randomizer`

## Requirements
- R1: After an asynchronous reset (rst_ni low), valid_o and data_o are 0 and all 15 register stages are 0, so the first randomized bit equals its input bit.
- R2: clear_i is synchronous and takes priority over valid_i: at the next edge every stage becomes 0 and valid_o and data_o go to 0.
- R3: In randomize mode (bypass_i=0, descramble_i=0) an accepted bit yields data_o = data_i XOR stage 14 XOR stage 15. Stage 1 holds the newest bit and stage 15 the oldest.
- R4: In randomize mode the output bit is the bit shifted into stage 1, and every other stage takes the value of its lower neighbour.
- R5: In de-randomize mode (bypass_i=0, descramble_i=1) data_o = data_i XOR stage 14 XOR stage 15, and data_i is the bit shifted into stage 1.
- R6: With bypass_i=1, whatever descramble_i is, data_o = data_i and the register keeps its contents. A later randomized bit therefore sees the state that was there before the bypass.
- R7: On a cycle with valid_i=0 and clear_i=0 the register and data_o hold their values and valid_o is 0 at the next edge.
- R8: Latency is exactly one cycle: a bit accepted at an edge appears on data_o together with valid_o=1 right after that edge.
- R9: A randomizer feeding a de-randomizer restores the original stream exactly from the 16th bit on, whatever the initial states of the two registers, including when gaps appear in the valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the register and the output |
| valid_i | input | 1 | data_i holds a bit this cycle |
| data_i | input | 1 | Serial input bit |
| bypass_i | input | 1 | 1: pass data through and freeze the register |
| descramble_i | input | 1 | 0: randomize, 1: de-randomize |
| valid_o | output | 1 | data_o holds a bit this cycle |
| data_o | output | 1 | Serial output bit |

## Verification
A single 1 followed by zeros shows the tap positions and that the output feeds back, which a free-running generator would not show. Random streams in each mode tell randomize feedback apart from de-randomize feedback. Bypass bursts placed between randomized bits show whether the register stays frozen, and valid gaps and a clear raised with valid show the hold and priority rules. A loop from a sender into a receiver with a deliberately mismatched history shows that the receiver locks onto the sender after 15 bits.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    MODE_RAND   = 2'd0,
    MODE_DERAND = 2'd1,
    MODE_PASS   = 2'd2
  } rnd_mode_e;

  // bypass wins over direction
  function automatic rnd_mode_e decode_mode(input logic bypass, input logic descramble);
    if (bypass)          return MODE_PASS;
    else if (descramble) return MODE_DERAND;
    else                 return MODE_RAND;
  endfunction
endpackage

// File: rtl/rnd_shift_reg.sv
module rnd_shift_reg #(
  parameter int STAGES = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  input  logic              bit_i,
  output logic [STAGES-1:0] state_o
);
  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] next_in;

  assign next_in[0] = bit_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i > 0) begin : g_link
      assign next_in[i] = state_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      state_q[i] <= 1'b0;
      else if (clear_i) state_q[i] <= 1'b0;
      else if (adv_i)   state_q[i] <= next_in[i];
    end
  end

  assign state_o = state_q;

  // R4
  shift_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clear_i) |=> state_q[STAGES-1:1] == $past(state_q[STAGES-2:0]));
endmodule

// File: rtl/rnd_mix.sv
module rnd_mix
  import rnd_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int TAP_A  = 14,
  parameter int TAP_B  = 15
) (
  input  logic [STAGES-1:0] state_i,
  input  logic              data_i,
  input  rnd_mode_e         mode_i,
  output logic              out_bit_o,
  output logic              shift_bit_o,
  output logic              shift_en_o
);
  logic [STAGES-1:0] tap_mask;
  logic              key_bit;

  for (genvar i = 0; i < STAGES; i++) begin : g_mask
    assign tap_mask[i] = (i == TAP_A - 1) || (i == TAP_B - 1);
  end

  assign key_bit = ^(state_i & tap_mask);

  always_comb begin
    out_bit_o   = data_i ^ key_bit;
    shift_bit_o = out_bit_o;
    shift_en_o  = 1'b1;
    unique case (mode_i)
      MODE_DERAND: shift_bit_o = data_i;
      MODE_PASS: begin
        out_bit_o  = data_i;
        shift_en_o = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rnd_out_stage.sv
module rnd_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic valid_o,
  output logic data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= 1'b0;
    end else if (clear_i) begin
      valid_o <= 1'b0;
      data_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= bit_i;
    end
  end
endmodule

// File: rtl/self_sync_randomizer.sv
module self_sync_randomizer
  import rnd_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int TAP_A  = 14,
  parameter int TAP_B  = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic valid_i,
  input  logic data_i,
  input  logic bypass_i,
  input  logic descramble_i,
  output logic valid_o,
  output logic data_o
);
  logic [STAGES-1:0] state_w;
  logic              out_bit, shift_bit, shift_en;
  rnd_mode_e         mode;

  assign mode = decode_mode(bypass_i, descramble_i);

  rnd_mix #(.STAGES(STAGES), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_mix (
    .state_i     (state_w),
    .data_i      (data_i),
    .mode_i      (mode),
    .out_bit_o   (out_bit),
    .shift_bit_o (shift_bit),
    .shift_en_o  (shift_en)
  );

  rnd_shift_reg #(.STAGES(STAGES)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .adv_i   (valid_i && shift_en),
    .bit_i   (shift_bit),
    .state_o (state_w)
  );

  rnd_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .valid_i (valid_i),
    .bit_i   (out_bit),
    .valid_o (valid_o),
    .data_o  (data_o)
  );

  // R2
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!valid_o && !data_o && state_w == '0));
  // R3
  rand_taps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && !bypass_i) |=>
      data_o == ($past(data_i) ^ $past(state_w[TAP_A-1]) ^ $past(state_w[TAP_B-1])));
  // R4
  rand_feedback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && !bypass_i && !descramble_i) |=> state_w[0] == data_o);
  // R5
  derand_feedback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && !bypass_i && descramble_i) |=> state_w[0] == $past(data_i));
  // R6
  bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && bypass_i) |=> (data_o == $past(data_i) && $stable(state_w)));
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i) |=> (!valid_o && $stable(state_w) && $stable(data_o)));
  // R8
  valid_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i) |=> valid_o);
endmodule

// File: tb/self_sync_randomizer_tb.sv
module self_sync_randomizer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic clr = 0, vin = 0, din = 0, byp = 0, des = 0;
  logic vo, dout;
  logic loop_en = 0, rx_v_drv = 0, rx_d_drv = 0;
  logic rx_vin, rx_din, rx_vo, rx_dout;

  assign rx_vin = loop_en ? vo   : rx_v_drv;
  assign rx_din = loop_en ? dout : rx_d_drv;

  self_sync_randomizer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .valid_i(vin), .data_i(din),
    .bypass_i(byp), .descramble_i(des), .valid_o(vo), .data_o(dout));

  self_sync_randomizer u_rx (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(1'b0), .valid_i(rx_vin), .data_i(rx_din),
    .bypass_i(1'b0), .descramble_i(1'b1), .valid_o(rx_vo), .data_o(rx_dout));

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [14:0] ms = '0;
  logic ev = 0, ed = 0;
  bit   log_en = 0;
  logic orig [0:1023];
  int   n_log = 0, rx_idx = 0;

  function automatic logic key(input logic [14:0] s);
    return s[13] ^ s[14];
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic d, input logic c,
                      input logic b, input logic s, input string tag);
    logic o;
    @(negedge clk);
    vin = v; din = d; clr = c; byp = b; des = s;
    @(posedge clk);
    if (c) begin
      ms = '0; ev = 0; ed = 0;
    end else if (v) begin
      o = b ? d : (d ^ key(ms));
      if (!b) ms = {ms[13:0], (s ? d : o)};
      ev = 1; ed = o;
      if (log_en && !b && !s) begin orig[n_log] = d; n_log++; end
    end else begin
      ev = 0;
    end
    #1;
    chk({tag, " valid"}, vo, ev);
    chk({tag, " data"}, dout, ed);
  endtask

  // R9: receiver output checked from the 16th looped bit on
  always @(posedge clk) begin
    #2;
    if (loop_en && rx_vo) begin
      if (rx_idx >= 15 && rx_idx < n_log) chk("R9 loop", rx_dout, orig[rx_idx]);
      rx_idx++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", vo, 1'b0);
    chk("R1 reset data", dout, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R1: zero state leaves first bits untouched
    step(1, 1, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, "R1");

    // R3 R4: impulse after clear exposes taps and feedback
    step(0, 0, 1, 0, 0, "R2");
    step(1, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 0, "R3");

    // R3 random randomize stream
    for (int i = 0; i < 200; i++) step(1, 1'($urandom), 0, 0, 0, "R3");
    // R5 random de-randomize stream
    for (int i = 0; i < 200; i++) step(1, 1'($urandom), 0, 0, 1, "R5");

    // R6: bypass bursts between randomized bits, register frozen
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < 5; i++) step(1, 1'($urandom), 0, 0, 0, "R6");
      for (int i = 0; i < 4; i++) step(1, 1'($urandom), 0, 1, 1'($urandom), "R6");
    end

    // R7: gaps with toggling data
    for (int i = 0; i < 100; i++)
      step(1'(($urandom % 3) != 0), 1'($urandom), 0, 0, 0, "R7");

    // R8: single bit after idle
    step(0, 1, 0, 0, 0, "R8");
    step(1, 1, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");

    // R2: clear with valid high mid-stream
    for (int i = 0; i < 20; i++) step(1, 1'($urandom), 0, 0, 0, "R2");
    step(1, 1, 1, 0, 0, "R2");
    step(1, 1, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, "R2");

    // mixed random controls
    for (int i = 0; i < 600; i++)
      step(1'(($urandom % 4) != 0), 1'($urandom), 1'(($urandom % 50) == 0),
           1'(($urandom % 6) == 0), 1'($urandom), "R3 R5 R6 R7");

    // R9: give receiver its own history, leave sender state as is
    for (int i = 0; i < 40; i++) begin
      rx_v_drv = 1; rx_d_drv = 1'($urandom);
      step(0, 0, 0, 0, 0, "R7");
    end
    rx_v_drv = 0;
    step(0, 0, 0, 0, 0, "R7");
    loop_en = 1; log_en = 1;
    for (int i = 0; i < 400; i++)
      step(1'(($urandom % 5) != 0), 1'($urandom), 0, 0, 0, "R9");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R9");
    chk("R9 count", 1'(rx_idx == n_log), 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule